// File: doc/BRIEF.md
# Match-Frequency Square-Wave Timer

This block is one timer channel that produces a square wave whose half-period comes from compare register 0. A prescaler turns the input clock into a count-enable pulse. The counter advances on each pulse, up or down. When the counter reaches its end value, an update event occurs. Each update event flips the waveform output and sets a sticky overflow flag. The flag drives an interrupt line when the interrupt enable is set.

Software controls the channel through a flat register interface. Writes take effect on a single write strobe. Reads are combinational from a separate read address. The waveform-select field chooses between match-frequency mode and a placeholder mode. In match-frequency mode, compare register 0 sets the top of the count. In the placeholder mode, a period register sets the top and the output does not toggle.

A two-state machine controls whether the channel counts. The states are IDLE and RUN. The transition START (IDLE to RUN) is taken when the enable bit is 1. The transition STOP (RUN to IDLE) is taken when the enable bit is 0. Counting happens only in RUN while the enable bit is still set.

Top module: `mfrq_timer`

## Requirements
- R1: The waveform-select field is CTRL bits [10:8]. Value 1 selects match-frequency mode, in which the counter top is compare register 0 (address 3) and the period register (address 4) is ignored. Any other value selects placeholder mode. In placeholder mode the top is the period register, update events and the flag still occur, and the waveform output holds its level.
- R2: In match-frequency mode the waveform output toggles once per update event. The spacing between toggles is (top+1) × divide-ratio input clock cycles.
- R3: The prescaler code is CTRL bits [6:4]. Codes 0 to 7 divide the clock by 1, 2, 4, 8, 16, 64, 256 and 1024. The division is a count-enable pulse, not a derived clock.
- R4: One direction bit selects the count direction. Writing data bit 0 = 1 to address 1 selects up (direction bit 0). Writing data bit 0 = 1 to address 2 selects down (direction bit 1). A write with data bit 0 = 0 to either address leaves the direction unchanged. Both addresses read the direction in bit 0.
- R5: Counting up, the count runs 0..top, and the update event occurs on the pulse that sees count ≥ top, which wraps the count to 0. Counting down, the update event occurs on the pulse that sees count 0, which reloads the count from top. The count reads at address 8.
- R6: Bit 0 of address 5 inverts the waveform output after generation. The inversion is visible in the cycle after the write.
- R7: Each update event sets the overflow flag, which reads in bit 0 of address 7. Writing 1 to that bit clears the flag. When an update and a clear occur in the same cycle, the flag stays set. The interrupt output equals the flag ANDed with the enable in bit 0 of address 6.
- R8: CTRL bit 0 enables counting. While it is 0, the count and the waveform output hold their values.
- R9: A write to compare register 0 takes effect at once. If the count is already at or above the new top while counting up, the next count pulse produces an update event.
- R10: After reset, all registers read 0, the waveform output is 0 and the interrupt output is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | ADDR_W | Write address |
| wr_data | input | DATA_W | Write data |
| rd_addr | input | ADDR_W | Read address |
| rd_data | output | DATA_W | Combinational read data |
| wave_o | output | 1 | Square-wave output after optional inversion |
| irq_o | output | 1 | Overflow interrupt |

## Verification
The hardest case to reach from the ports is a flag-clear write that arrives in the same cycle as an update event. The bench makes this happen with prescaler code 0 and a top of 3, which gives an update every 4 cycles. It waits for an observed output toggle, which marks one update edge. It then times the clear write so that the write is captured exactly four edges later. A second clear, written just after a toggle, shows that a clear on its own does take effect. The bench also forces an early update by lowering compare register 0 below the running count.

// File: rtl/mfrq_pkg.sv
package mfrq_pkg;

    typedef enum logic [0:0] {
        ST_IDLE = 1'b0,
        ST_RUN  = 1'b1
    } run_state_t;

    // Register addresses
    localparam int A_CTRL   = 0;
    localparam int A_DIRCLR = 1;
    localparam int A_DIRSET = 2;
    localparam int A_CMP0   = 3;
    localparam int A_PER    = 4;
    localparam int A_DRV    = 5;
    localparam int A_IEN    = 6;
    localparam int A_IFLAG  = 7;
    localparam int A_COUNT  = 8;

    // CTRL field positions
    localparam int CTRL_EN_BIT = 0;
    localparam int PRE_LSB     = 4;
    localparam int WSEL_LSB    = 8;
    localparam int FIELD_W     = 3;

    localparam logic [FIELD_W-1:0] WSEL_MATCH_FREQ = 3'd1;
    localparam int PRE_SHIFT_MAX = 10;

    function automatic int unsigned pre_shift(input logic [FIELD_W-1:0] code);
        case (code)
            3'd0:    return 0;
            3'd1:    return 1;
            3'd2:    return 2;
            3'd3:    return 3;
            3'd4:    return 4;
            3'd5:    return 6;
            3'd6:    return 8;
            default: return 10;
        endcase
    endfunction

endpackage

// File: rtl/mfrq_prescaler.sv
module mfrq_prescaler
    import mfrq_pkg::*;
#(
    parameter int DIV_W = PRE_SHIFT_MAX
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               run,
    input  logic [FIELD_W-1:0] code,
    output logic               tick
);

    logic [DIV_W-1:0] div_q;
    logic [DIV_W-1:0] div_lim;

    always_comb begin
        div_lim = DIV_W'((1 << pre_shift(code)) - 1);
        tick    = run && (div_q >= div_lim);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            div_q <= '0;
        end else if (!run || tick) begin
            div_q <= '0;
        end else begin
            div_q <= div_q + 1'b1;
        end
    end

endmodule

// File: rtl/mfrq_core.sv
module mfrq_core
    import mfrq_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             en,
    input  logic             tick,
    input  logic             mode_mfrq,
    input  logic             dir_down,
    input  logic [CNT_W-1:0] top,
    output logic             run,
    output logic             upd,
    output logic [CNT_W-1:0] cnt,
    output logic             wave_raw
);

    run_state_t       state_q;
    run_state_t       state_d;
    logic [CNT_W-1:0] cnt_q;
    logic             wave_q;
    logic             end_hit;

    // Next-state logic: START and STOP transitions
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: if (en)  state_d = ST_RUN;
            ST_RUN:  if (!en) state_d = ST_IDLE;
            default: state_d = ST_IDLE;
        endcase
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // Outputs of the state machine
    always_comb begin
        run     = (state_q == ST_RUN) && en;
        end_hit = dir_down ? (cnt_q == '0) : (cnt_q >= top);
        upd     = run && tick && end_hit;
    end

    // Counter and waveform datapath
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q  <= '0;
            wave_q <= 1'b0;
        end else begin
            if (upd) begin
                cnt_q <= dir_down ? top : '0;
            end else if (run && tick) begin
                cnt_q <= dir_down ? cnt_q - 1'b1 : cnt_q + 1'b1;
            end
            if (upd && mode_mfrq) begin
                wave_q <= ~wave_q;
            end
        end
    end

    assign cnt      = cnt_q;
    assign wave_raw = wave_q;

endmodule

// File: rtl/mfrq_regs.sv
module mfrq_regs
    import mfrq_pkg::*;
#(
    parameter int DATA_W = 32,
    parameter int CNT_W  = 16,
    parameter int ADDR_W = 4
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               wr_en,
    input  logic [ADDR_W-1:0]  wr_addr,
    input  logic [DATA_W-1:0]  wr_data,
    input  logic [ADDR_W-1:0]  rd_addr,
    output logic [DATA_W-1:0]  rd_data,
    input  logic               upd,
    input  logic [CNT_W-1:0]   cnt,
    output logic               en,
    output logic [FIELD_W-1:0] pre_code,
    output logic               mode_mfrq,
    output logic               dir_down,
    output logic [CNT_W-1:0]   top,
    output logic               inv,
    output logic               flag,
    output logic               irq
);

    logic               en_q;
    logic [FIELD_W-1:0] pre_q;
    logic [FIELD_W-1:0] wsel_q;
    logic               dir_q;
    logic [CNT_W-1:0]   cmp0_q;
    logic [CNT_W-1:0]   per_q;
    logic               inv_q;
    logic               ien_q;
    logic               flag_q;
    logic               clr_req;
    logic               unused_wr_bits;

    assign unused_wr_bits = ^wr_data;
    assign clr_req = wr_en && (wr_addr == ADDR_W'(A_IFLAG)) && wr_data[0];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            en_q   <= 1'b0;
            pre_q  <= '0;
            wsel_q <= '0;
            dir_q  <= 1'b0;
            cmp0_q <= '0;
            per_q  <= '0;
            inv_q  <= 1'b0;
            ien_q  <= 1'b0;
        end else if (wr_en) begin
            case (wr_addr)
                ADDR_W'(A_CTRL): begin
                    en_q   <= wr_data[CTRL_EN_BIT];
                    pre_q  <= wr_data[PRE_LSB +: FIELD_W];
                    wsel_q <= wr_data[WSEL_LSB +: FIELD_W];
                end
                ADDR_W'(A_DIRCLR): if (wr_data[0]) dir_q <= 1'b0;
                ADDR_W'(A_DIRSET): if (wr_data[0]) dir_q <= 1'b1;
                ADDR_W'(A_CMP0):   cmp0_q <= wr_data[CNT_W-1:0];
                ADDR_W'(A_PER):    per_q  <= wr_data[CNT_W-1:0];
                ADDR_W'(A_DRV):    inv_q  <= wr_data[0];
                ADDR_W'(A_IEN):    ien_q  <= wr_data[0];
                default: ;
            endcase
        end
    end

    // Sticky flag: a new update wins over a clear in the same cycle
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            flag_q <= 1'b0;
        end else if (upd) begin
            flag_q <= 1'b1;
        end else if (clr_req) begin
            flag_q <= 1'b0;
        end
    end

    always_comb begin
        rd_data = '0;
        case (rd_addr)
            ADDR_W'(A_CTRL): begin
                rd_data[CTRL_EN_BIT]         = en_q;
                rd_data[PRE_LSB +: FIELD_W]  = pre_q;
                rd_data[WSEL_LSB +: FIELD_W] = wsel_q;
            end
            ADDR_W'(A_DIRCLR): rd_data[0] = dir_q;
            ADDR_W'(A_DIRSET): rd_data[0] = dir_q;
            ADDR_W'(A_CMP0):   rd_data[CNT_W-1:0] = cmp0_q;
            ADDR_W'(A_PER):    rd_data[CNT_W-1:0] = per_q;
            ADDR_W'(A_DRV):    rd_data[0] = inv_q;
            ADDR_W'(A_IEN):    rd_data[0] = ien_q;
            ADDR_W'(A_IFLAG):  rd_data[0] = flag_q;
            ADDR_W'(A_COUNT):  rd_data[CNT_W-1:0] = cnt;
            default: ;
        endcase
    end

    always_comb begin
        en        = en_q;
        pre_code  = pre_q;
        mode_mfrq = (wsel_q == WSEL_MATCH_FREQ);
        dir_down  = dir_q;
        top       = mode_mfrq ? cmp0_q : per_q;
        inv       = inv_q;
        flag      = flag_q;
        irq       = flag_q && ien_q;
    end

endmodule

// File: rtl/mfrq_timer.sv
module mfrq_timer
    import mfrq_pkg::*;
#(
    parameter int CNT_W  = 16,
    parameter int DATA_W = 32,
    parameter int ADDR_W = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic [DATA_W-1:0] rd_data,
    output logic              wave_o,
    output logic              irq_o
);

    localparam int DIV_W = PRE_SHIFT_MAX;

    logic               en;
    logic [FIELD_W-1:0] pre_code;
    logic               mode_mfrq;
    logic               dir_down;
    logic [CNT_W-1:0]   top;
    logic               inv;
    logic               flag;
    logic               run;
    logic               tick;
    logic               upd;
    logic [CNT_W-1:0]   cnt;
    logic               wave_raw;

    mfrq_regs #(
        .DATA_W (DATA_W),
        .CNT_W  (CNT_W),
        .ADDR_W (ADDR_W)
    ) regs_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_en     (wr_en),
        .wr_addr   (wr_addr),
        .wr_data   (wr_data),
        .rd_addr   (rd_addr),
        .rd_data   (rd_data),
        .upd       (upd),
        .cnt       (cnt),
        .en        (en),
        .pre_code  (pre_code),
        .mode_mfrq (mode_mfrq),
        .dir_down  (dir_down),
        .top       (top),
        .inv       (inv),
        .flag      (flag),
        .irq       (irq_o)
    );

    mfrq_prescaler #(
        .DIV_W (DIV_W)
    ) pre_i (
        .clk   (clk),
        .rst_n (rst_n),
        .run   (run),
        .code  (pre_code),
        .tick  (tick)
    );

    mfrq_core #(
        .CNT_W (CNT_W)
    ) core_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .en        (en),
        .tick      (tick),
        .mode_mfrq (mode_mfrq),
        .dir_down  (dir_down),
        .top       (top),
        .run       (run),
        .upd       (upd),
        .cnt       (cnt),
        .wave_raw  (wave_raw)
    );

    assign wave_o = wave_raw ^ inv;

endmodule

// File: rtl/mfrq_timer_chk.sv
module mfrq_timer_chk #(
    parameter int CNT_W = 16
) (
    input logic             clk,
    input logic             rst_n,
    input logic             run,
    input logic             tick,
    input logic             upd,
    input logic             dir_down,
    input logic             mode_mfrq,
    input logic [CNT_W-1:0] cnt,
    input logic [CNT_W-1:0] top,
    input logic             wave_raw,
    input logic             flag
);

    p_up_wrap_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (run && tick && !dir_down && (cnt >= top)) |=> (cnt == '0));

    p_down_reload_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (run && tick && dir_down && (cnt == '0)) |=> (cnt == $past(top)));

    p_toggle_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (run && tick && mode_mfrq && (dir_down ? (cnt == '0) : (cnt >= top)))
        |=> (wave_raw != $past(wave_raw)));

    p_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !run |=> ($stable(cnt) && $stable(wave_raw)));

    p_flag_set_r7: assert property (@(posedge clk) disable iff (!rst_n)
        upd |=> flag);

    p_placeholder_r1: assert property (@(posedge clk) disable iff (!rst_n)
        !mode_mfrq |=> $stable(wave_raw));

    p_tick_gated_r3: assert property (@(posedge clk) disable iff (!rst_n)
        tick |-> run);

endmodule

bind mfrq_timer mfrq_timer_chk #(.CNT_W(CNT_W)) chk_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .run       (run),
    .tick      (tick),
    .upd       (upd),
    .dir_down  (dir_down),
    .mode_mfrq (mode_mfrq),
    .cnt       (cnt),
    .top       (top),
    .wave_raw  (wave_raw),
    .flag      (flag)
);

// File: tb/mfrq_timer_tb_top.sv
module mfrq_timer_tb_top;

    localparam logic [3:0] T_CTRL = 4'd0, T_DCLR = 4'd1, T_DSET = 4'd2, T_CMP0 = 4'd3,
                           T_PER = 4'd4, T_DRV = 4'd5, T_IEN = 4'd6, T_FLAG = 4'd7,
                           T_CNT = 4'd8;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [3:0]  wr_addr = '0;
    logic [31:0] wr_data = '0;
    logic [3:0]  rd_addr = '0;
    logic [31:0] rd_data;
    logic        wave_o;
    logic        irq_o;

    int     n_chk = 0;
    int     n_fail = 0;
    longint cyc = 0;
    longint last_edge = 0;
    int     edge_cnt = 0;
    logic   prev_wave = 1'b0;
    longint exp_q[$];
    longint exp_v;

    mfrq_timer dut_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (wr_en),
        .wr_addr (wr_addr),
        .wr_data (wr_data),
        .rd_addr (rd_addr),
        .rd_data (rd_data),
        .wave_o  (wave_o),
        .irq_o   (irq_o)
    );

    always #2 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    task automatic check(input bit ok, input string req, input longint act, input longint exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: got %0d expected %0d", req, act, exp);
        end
    endtask

    // Monitor: pops expected toggle spacings and compares them
    always @(negedge clk) begin
        if (rst_n && (wave_o !== prev_wave)) begin
            if (exp_q.size() > 0) begin
                exp_v = exp_q.pop_front();
                check((cyc - last_edge) == exp_v, "R2 R3 toggle spacing", cyc - last_edge, exp_v);
            end
            last_edge = cyc;
            edge_cnt++;
        end
        prev_wave = wave_o;
    end

    function automatic longint ratio(input int code);
        case (code)
            0: return 1;
            1: return 2;
            2: return 4;
            3: return 8;
            4: return 16;
            5: return 64;
            6: return 256;
            default: return 1024;
        endcase
    endfunction

    function automatic logic [31:0] ctrl_val(input bit en, input int code, input int wsel);
        return 32'(en) | (32'(code) << 4) | (32'(wsel) << 8);
    endfunction

    task automatic wr(input logic [3:0] a, input logic [31:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic rd(input logic [3:0] a, output logic [31:0] d);
        rd_addr = a;
        #1;
        d = rd_data;
    endtask

    task automatic wait_edge();
        int e;
        e = edge_cnt;
        wait (edge_cnt != e);
    endtask

    // Driver: configure, resynchronise, push expected spacings, wait for drain
    task automatic run_period(input int code, input int top, input bit down, input int n);
        wr(T_CMP0, 32'(top));
        wr(down ? T_DSET : T_DCLR, 32'd1);
        wr(T_CTRL, ctrl_val(1'b1, code, 1));
        wait_edge();
        wait_edge();
        for (int i = 0; i < n; i++) exp_q.push_back(ratio(code) * longint'(top + 1));
        wait (exp_q.size() == 0);
    endtask

    task automatic finish_run();
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog expired (all requirements): got %0d expected %0d", cyc, 150000);
        finish_run();
    end

    initial begin
        logic [31:0] d;
        logic [31:0] c1;
        logic [31:0] c2;
        logic        w;
        int          e;

        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R10 reset state
        rd(T_CTRL, d);  check(d == 0, "R10 ctrl reset", d, 0);
        rd(T_CNT, d);   check(d == 0, "R10 count reset", d, 0);
        rd(T_FLAG, d);  check(d == 0, "R10 flag reset", d, 0);
        rd(T_DSET, d);  check(d == 0, "R10 direction reset", d, 0);
        check(wave_o == 1'b0, "R10 wave reset", wave_o, 0);
        check(irq_o == 1'b0, "R10 irq reset", irq_o, 0);

        // R3: every prescaler code, up counting
        for (int code = 0; code < 8; code++) run_period(code, 2, 1'b0, 2);

        // R2 R5: several top values, both directions
        run_period(0, 0, 1'b0, 3);
        run_period(0, 7, 1'b0, 3);
        run_period(2, 13, 1'b0, 2);
        run_period(1, 3, 1'b1, 3);
        run_period(0, 9, 1'b1, 3);

        // R5 down-count step and reload
        wr(T_CMP0, 32'd20);
        @(negedge clk);
        rd(T_CNT, c1);
        @(negedge clk);
        rd(T_CNT, c2);
        check(c2 == ((c1 == 0) ? 32'd20 : c1 - 1), "R5 down step", c2, (c1 == 0) ? 20 : c1 - 1);

        // R4 direction set/clear registers
        wr(T_DCLR, 32'd0);
        rd(T_DCLR, d); check(d[0] == 1'b1, "R4 clear with 0 ignored", d[0], 1);
        wr(T_DCLR, 32'd1);
        rd(T_DSET, d); check(d[0] == 1'b0, "R4 clear selects up", d[0], 0);
        wr(T_DSET, 32'd0);
        rd(T_DSET, d); check(d[0] == 1'b0, "R4 set with 0 ignored", d[0], 0);
        @(negedge clk);
        rd(T_CNT, c1);
        @(negedge clk);
        rd(T_CNT, c2);
        check(c2 == ((c1 >= 20) ? 32'd0 : c1 + 1), "R5 up step", c2, (c1 >= 20) ? 0 : c1 + 1);

        // R9 immediate compare write below running count
        run_period(0, 200, 1'b0, 1);
        wait_edge();
        repeat (50) @(negedge clk);
        e = edge_cnt;
        wr(T_CMP0, 32'd10);
        @(negedge clk);
        #1;
        check(edge_cnt == e + 1, "R9 early update after compare write", edge_cnt - e, 1);
        exp_q.push_back(11);
        exp_q.push_back(11);
        wait (exp_q.size() == 0);

        // R7 flag, interrupt enable, clear, clear colliding with update
        rd(T_FLAG, d); check(d[0] == 1'b1, "R7 flag set by update", d[0], 1);
        check(irq_o == 1'b0, "R7 irq masked", irq_o, 0);
        wr(T_IEN, 32'd1);
        check(irq_o == 1'b1, "R7 irq enabled", irq_o, 1);
        run_period(0, 50, 1'b0, 1);
        wait_edge();
        wr(T_FLAG, 32'd1);
        rd(T_FLAG, d); check(d[0] == 1'b0, "R7 flag cleared", d[0], 0);
        check(irq_o == 1'b0, "R7 irq drops on clear", irq_o, 0);
        run_period(0, 3, 1'b0, 1);
        wait_edge();
        repeat (2) @(negedge clk);
        wr(T_FLAG, 32'd1);
        rd(T_FLAG, d); check(d[0] == 1'b1, "R7 update wins over clear", d[0], 1);
        wr(T_IEN, 32'd0);

        // R8 freeze and R6 inversion
        wr(T_CMP0, 32'd30);
        wr(T_CTRL, ctrl_val(1'b0, 0, 1));
        rd(T_CNT, c1);
        w = wave_o;
        repeat (40) @(negedge clk);
        rd(T_CNT, c2);
        check(c1 == c2, "R8 count frozen", c2, c1);
        check(wave_o == w, "R8 wave held", wave_o, w);
        wr(T_DRV, 32'd1);
        check(wave_o == !w, "R6 inverted", wave_o, !w);
        wr(T_DRV, 32'd0);
        check(wave_o == w, "R6 inversion removed", wave_o, w);
        wr(T_CTRL, ctrl_val(1'b1, 0, 1));
        repeat (3) @(negedge clk);
        rd(T_CNT, c2);
        check(c1 != c2, "R8 count resumes", c2, c1 + 1);

        // R1 placeholder mode: period register sets top, output holds
        wr(T_CTRL, ctrl_val(1'b0, 0, 0));
        wr(T_PER, 32'd3);
        wr(T_CMP0, 32'd50);
        wr(T_FLAG, 32'd1);
        wr(T_CTRL, ctrl_val(1'b1, 0, 0));
        w = wave_o;
        for (int i = 0; i < 6; i++) begin
            repeat (5) @(negedge clk);
            rd(T_CNT, d);
            check(d <= 32'd3, "R1 count bounded by period register", d, 3);
        end
        check(wave_o == w, "R1 output holds", wave_o, w);
        rd(T_FLAG, d); check(d[0] == 1'b1, "R1 update still flags", d[0], 1);

        finish_run();
    end

endmodule